// File: doc/BRIEF.md
# Interrupt Status and Enable Register Bank

This block holds the interrupt registers of a USB host controller. Eight hardware sources report events as one-cycle strobes. Each strobe latches a sticky bit in a status register. Software clears a status bit by writing a one to it. A single enable mask selects which sources may raise the interrupt line. Software changes that mask through two addresses: writing ones at one address turns bits on, and writing ones at the other turns bits off. Both addresses read back the same mask.

Bit 31 of the enable mask is a master switch over every source. The interrupt output is high when the master switch is on and at least one status bit in positions 0 to 30 is both set and enabled. Reads are combinational from the word address. Writes and events take effect at the next rising clock edge.

Top module: `irq_reg_bank`

## Requirements
- R1: After synchronous reset, every register reads zero and `irq_out` is low.
- R2: A strobe on `evt_src[i]` sets a sticky status bit at a fixed position: index 0 to 6 go to bits 0 to 6 (scheduling overrun, done-head write-back, start of frame, resume detect, unrecoverable error, frame number overflow, root hub status change), and index 7 goes to bit 30 (ownership change). The bit stays set after the strobe ends.
- R3: A write at word address 0 (status) clears each status bit whose write-data bit is 1. Bits written with 0 keep their value.
- R4: When a strobe and a status clear hit the same bit in the same cycle, the bit ends up set.
- R5: A write at word address 1 (enable-set) sets each enable bit whose write-data bit is 1. Bits written with 0 keep their value.
- R6: A write at word address 2 (enable-clear) clears each enable bit whose write-data bit is 1. Bits written with 0 keep their value.
- R7: Reads at word addresses 1 and 2 both return the current enable mask.
- R8: `irq_out` is high exactly when enable bit 31 is 1 and status AND enable is nonzero in bits 0 to 30.
- R9: Bits 7 to 29 of every register read zero and ignore writes. Status bit 31 reads zero. Any other word address reads zero and ignores writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | ADDR_W | Word address for read and write |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| evt_src | input | NUM_SRC | One event strobe per interrupt source |
| irq_out | output | 1 | Interrupt request |

## Verification
The assertions assume that event strobes and write strobes are clean, known values at every rising edge after reset. They also assume that only one register address is written in a given cycle, so a set and a clear of the same enable bit never meet. The bench follows these rules. It changes every input on the falling edge, drives a single write at a time, and holds the event lines low except during a deliberate one-cycle pulse. The bench issues a strobe and a status clear for the same bit in the same cycle on purpose, because the design defines that case.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;

    localparam int DATA_W     = 32;
    localparam int NUM_SRC    = 8;
    localparam int LOW_SRCS   = 7;
    localparam int HIGH_POS   = 30;
    localparam int MASTER_BIT = 31;

    typedef logic [DATA_W-1:0] word_t;

    localparam int unsigned OFS_STATUS = 0;
    localparam int unsigned OFS_EN_SET = 1;
    localparam int unsigned OFS_EN_CLR = 2;

    typedef enum logic [1:0] {
        SEL_STATUS = 2'd0,
        SEL_EN_SET = 2'd1,
        SEL_EN_CLR = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        word_t sts_clr;
        word_t en_set;
        word_t en_clr;
    } wr_ops_t;

    function automatic int src_pos(input int idx);
        return (idx < LOW_SRCS) ? idx : HIGH_POS;
    endfunction

    function automatic word_t calc_sts_mask();
        word_t m;
        m = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            m[src_pos(i)] = 1'b1;
        end
        return m;
    endfunction

    localparam word_t STS_MASK = calc_sts_mask();
    localparam word_t EN_MASK  = STS_MASK | (word_t'(1) << MASTER_BIT);

endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
    import irq_bank_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  word_t             wdata,
    output reg_sel_e          sel,
    output wr_ops_t           ops
);

    always_comb begin
        if (addr == ADDR_W'(OFS_STATUS))      sel = SEL_STATUS;
        else if (addr == ADDR_W'(OFS_EN_SET)) sel = SEL_EN_SET;
        else if (addr == ADDR_W'(OFS_EN_CLR)) sel = SEL_EN_CLR;
        else                                  sel = SEL_NONE;
    end

    always_comb begin
        ops = '0;
        if (wr) begin
            unique case (sel)
                SEL_STATUS: ops.sts_clr = wdata & STS_MASK;
                SEL_EN_SET: ops.en_set  = wdata & EN_MASK;
                SEL_EN_CLR: ops.en_clr  = wdata & EN_MASK;
                default:    ops = '0;
            endcase
        end
    end

    always_comb begin
        assert ($countones({|ops.sts_clr, |ops.en_set, |ops.en_clr}) <= 1)
            else $error("p_one_target_r9: write reached more than one register");
    end

endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank
    import irq_bank_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  word_t evt_vec,
    input  word_t clr_vec,
    output word_t sts
);

    word_t sts_q;

    always_ff @(posedge clk) begin
        if (rst) sts_q <= '0;
        else     sts_q <= ((sts_q & ~clr_vec) | evt_vec) & STS_MASK;
    end

    assign sts = sts_q;

    p_evt_sets_r2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((sts_q & ($past(evt_vec) & STS_MASK)) == ($past(evt_vec) & STS_MASK)));

    p_clr_works_r3: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((sts_q & $past(clr_vec) & ~$past(evt_vec)) == '0));

    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (evt_vec == '0 && clr_vec == '0) |=> $stable(sts_q));

    p_evt_wins_r4: assert property (@(posedge clk) disable iff (rst)
        ((evt_vec & clr_vec & STS_MASK) != '0)
        |=> ((sts_q & $past(evt_vec & clr_vec & STS_MASK)) != '0));

    p_sts_unused_r9: assert property (@(posedge clk) disable iff (rst)
        (sts_q & ~STS_MASK) == '0);

endmodule

// File: rtl/irq_enable_bank.sv
module irq_enable_bank
    import irq_bank_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  word_t set_vec,
    input  word_t clr_vec,
    output word_t en
);

    word_t en_q;

    always_ff @(posedge clk) begin
        if (rst) en_q <= '0;
        else     en_q <= ((en_q & ~clr_vec) | set_vec) & EN_MASK;
    end

    assign en = en_q;

    p_set_r5: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((en_q & $past(set_vec)) == $past(set_vec)));

    p_clr_r6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((en_q & $past(clr_vec)) == '0));

    p_en_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (set_vec == '0 && clr_vec == '0) |=> $stable(en_q));

    p_en_unused_r9: assert property (@(posedge clk) disable iff (rst)
        (en_q & ~EN_MASK) == '0);

endmodule

// File: rtl/irq_reg_bank.sv
module irq_reg_bank
    import irq_bank_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic                reg_wr,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    input  logic [NUM_SRC-1:0]  evt_src,
    output logic                irq_out
);

    reg_sel_e sel;
    wr_ops_t  ops;
    word_t    evt_vec;
    word_t    sts;
    word_t    en;
    word_t    pending;

    irq_reg_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr  (reg_addr),
        .wr    (reg_wr),
        .wdata (reg_wdata),
        .sel   (sel),
        .ops   (ops)
    );

    always_comb begin
        evt_vec = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            evt_vec[src_pos(i)] = evt_src[i];
        end
    end

    irq_status_bank u_status (
        .clk     (clk),
        .rst     (rst),
        .evt_vec (evt_vec),
        .clr_vec (ops.sts_clr),
        .sts     (sts)
    );

    irq_enable_bank u_enable (
        .clk     (clk),
        .rst     (rst),
        .set_vec (ops.en_set),
        .clr_vec (ops.en_clr),
        .en      (en)
    );

    always_comb begin
        unique case (sel)
            SEL_STATUS: reg_rdata = sts;
            SEL_EN_SET,
            SEL_EN_CLR: reg_rdata = en;
            default:    reg_rdata = '0;
        endcase
    end

    assign pending = sts & en & STS_MASK;
    assign irq_out = en[MASTER_BIT] & (|pending);

    p_irq_master_r8: assert property (@(posedge clk) disable iff (rst)
        irq_out |-> en[MASTER_BIT]);

    p_irq_source_r8: assert property (@(posedge clk) disable iff (rst)
        irq_out |-> ((sts & en) != '0));

    p_mask_same_r7: assert property (@(posedge clk) disable iff (rst)
        (sel == SEL_EN_CLR) |-> (reg_rdata == en));

    p_rd_unused_r9: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata[29:7] == '0) && !reg_rdata[31] || sel != SEL_STATUS);

endmodule

// File: tb/test_irq_reg_bank.sv
module test_irq_reg_bank;

    localparam int AW = 4;
    localparam int NS = 8;
    localparam logic [31:0] STSM = 32'h4000_007F;
    localparam logic [31:0] ENM  = 32'hC000_007F;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] reg_addr = '0;
    logic          reg_wr = 1'b0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [NS-1:0] evt_src = '0;
    logic          irq_out;

    int n_chk = 0;
    int n_err = 0;
    logic [31:0] m_sts = '0;
    logic [31:0] m_en  = '0;

    always #2 clk = ~clk;

    irq_reg_bank #(.ADDR_W(AW)) i_irq_reg_bank (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .evt_src(evt_src), .irq_out(irq_out)
    );

    function automatic int pos_of(input int i);
        return (i < 7) ? i : 30;
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic rd(input int a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = AW'(a);
        #1 v = reg_rdata;
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = AW'(a); reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic pulse(input logic [NS-1:0] e);
        @(negedge clk);
        evt_src = e;
        @(posedge clk);
        @(negedge clk);
        evt_src = '0;
    endtask

    function automatic logic exp_irq();
        return m_en[31] & (|(m_sts & m_en & STSM));
    endfunction

    task automatic check_all(input string req);
        logic [31:0] v;
        rd(0, v); check({req, " status"}, v, m_sts);
        rd(1, v); check({req, " en-set"}, v, m_en);
        rd(2, v); check({req, " en-clr"}, v, m_en);
        check({req, " irq"}, {31'd0, irq_out}, {31'd0, exp_irq()});
    endtask

    task automatic t_reset();
        check_all("R1 reset");
    endtask

    task automatic t_events();
        for (int i = 0; i < NS; i++) begin
            logic [31:0] v;
            pulse(NS'(1) << i);
            m_sts[pos_of(i)] = 1'b1;
            repeat (2) @(posedge clk);
            rd(0, v);
            check("R2 sticky event bit", v, m_sts);
        end
    endtask

    task automatic t_w1c();
        logic [31:0] v;
        wr(0, 32'h0);
        rd(0, v); check("R3 zero write keeps status", v, m_sts);
        wr(0, 32'h4000_0005);
        m_sts &= ~32'h4000_0005;
        rd(0, v); check("R3 w1c selected bits", v, m_sts);
        wr(0, 32'hFFFF_FFFF);
        m_sts = '0;
        rd(0, v); check("R3 w1c all", v, m_sts);
    endtask

    task automatic t_collision();
        logic [31:0] v;
        pulse(8'h03);
        m_sts |= 32'h3;
        @(negedge clk);
        reg_addr = AW'(0); reg_wdata = 32'h0000_0003; reg_wr = 1'b1; evt_src = 8'h02;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0; evt_src = '0;
        m_sts = 32'h0000_0002;
        rd(0, v); check("R4 event beats clear", v, m_sts);
        wr(0, 32'h2); m_sts = '0;
    endtask

    task automatic t_enable();
        logic [31:0] v;
        wr(1, 32'h0000_0011); m_en |= 32'h11;
        check_all("R5 set");
        wr(1, 32'h0); check_all("R5 zero write keeps mask");
        wr(2, 32'h0); check_all("R6 zero write keeps mask");
        wr(2, 32'h0000_0001); m_en &= ~32'h1;
        rd(1, v); check("R6 clear seen at set address R7", v, m_en);
        rd(2, v); check("R6 clear seen at clear address R7", v, m_en);
        wr(2, 32'hFFFF_FFFF); m_en = '0;
        check_all("R6 clear all");
    endtask

    task automatic t_irq();
        pulse(8'h04); m_sts |= 32'h4;
        wr(1, 32'h0000_0004); m_en |= 32'h4;
        check("R8 no master", {31'd0, irq_out}, 32'd0);
        wr(1, 32'h8000_0000); m_en[31] = 1'b1;
        check("R8 master and source", {31'd0, irq_out}, 32'd1);
        wr(2, 32'h0000_0004); m_en &= ~32'h4;
        check("R8 source disabled", {31'd0, irq_out}, 32'd0);
        pulse(8'h80); m_sts[30] = 1'b1;
        wr(1, 32'h4000_0000); m_en[30] = 1'b1;
        check("R8 ownership source", {31'd0, irq_out}, 32'd1);
        wr(0, 32'h4000_0004); m_sts = '0;
        check("R8 status cleared", {31'd0, irq_out}, 32'd0);
        check_all("R8 final");
        wr(2, 32'hFFFF_FFFF); m_en = '0;
    endtask

    task automatic t_unused();
        logic [31:0] v;
        wr(1, 32'hFFFF_FFFF); m_en = ENM;
        check_all("R9 enable unused bits");
        pulse(8'hFF); m_sts = STSM;
        check_all("R9 status unused bits");
        wr(3, 32'hFFFF_FFFF);
        rd(3, v); check("R9 unmapped address reads zero", v, 32'h0);
        check_all("R9 unmapped write ignored");
        wr(0, 32'hFFFF_FFFF); m_sts = '0;
        wr(2, 32'hFFFF_FFFF); m_en = '0;
        check_all("R9 cleanup");
    endtask

    initial begin
        #20000;
        n_chk++; n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_events();
        t_w1c();
        t_collision();
        t_enable();
        t_irq();
        t_unused();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    end

endmodule